// File: doc/BRIEF.md
# Power-Down Mode Sequencer

This block controls the clock enables of a small processor subsystem and decides which low-power level it is in. Software stops single modules by writing two stop registers over a simple register bus while the CPU keeps running. A sleep strobe then takes the subsystem into one of two retention levels. In light sleep only the CPU clock is cut. In deep sleep the CPU, both DMA channel groups and the graphics transfer unit are cut, and external memory is moved into self-refresh. Deep sleep is granted only when a fixed set of peripherals is already in module standby. If that set is incomplete, the block records a sticky error and falls back to light sleep.

An interrupt, a manual reset or a power-on reset ends either sleep level. An interrupt wake brings the domains back in a fixed order. A separate backup level cuts every clock, keeps memory in self-refresh and holds the memory clock enable high while the backup reset input is low. Only a power-on reset leaves it. The DMA engine is gated as two groups of six channels, never channel by channel.

Top module: `pdm_seq`

## Requirements
- R1: While `por_n` is low at a clock edge, the next cycle shows `mode_stat`=0 (run), both stop registers 0, `deep_err`=0, every clock enable 1, `mem_self_ref`=0 and `mem_cke_hold`=0.
- R2: A write with `reg_addr`=0 loads the peripheral stop register and with `reg_addr`=1 the domain stop register. `reg_rdata` returns the register chosen by `reg_addr`. A stop bit of 1 turns a clock off: in run, `periph_clk_en[i]` equals the inverse of peripheral stop bit i, and `gfx_clk_en` is the inverse of domain stop bit 2.
- R3: DMA channels are gated only in groups. Domain stop bit 0 turns off channels 0 to 5, and domain stop bit 1 turns off channels 6 to 11. `dma_grp_en[g]` is the inverse of bit g, and every channel of group g follows it.
- R4: `sleep_req` in run with `deep_sel`=0 gives `mode_stat`=1 in the next cycle. The CPU clock is off, and DMA, graphics and peripheral enables keep following the stop registers. `mem_self_ref` takes the value that `sleep_self_ref` had at the entry edge.
- R5: `sleep_req` with `deep_sel`=1, when all peripheral stop bits 0 to 9 are 1, gives `mode_stat`=2. CPU, both DMA groups and graphics are off, the peripheral enables still follow their stop bits, and `mem_self_ref`=1.
- R6: A deep-sleep request with any of peripheral stop bits 0 to 9 still 0 enters light sleep (`mode_stat`=1) instead. It also sets `deep_err`, which stays 1 until a power-on reset.
- R7: An `irq` in the same cycle as `sleep_req` cancels entry, and the block stays in run.
- R8: An `irq` in light or deep sleep starts a wake that takes three cycles. In the first cycle `mem_self_ref`=0, the CPU is off and DMA/graphics still hold their sleep values. In the second cycle DMA/graphics follow the stop registers. In the third cycle the CPU clock is on and `mode_stat`=0. While waking, `mode_stat`=4.
- R9: `mrst_n` low in run, light sleep or deep sleep gives run in the next cycle, with the CPU clock on. The stop registers and `deep_err` keep their values. Priority: `por_n`, then `mrst_n`, then `backup_req`, then `irq`/`sleep_req`.
- R10: `backup_req` outside backup gives `mode_stat`=3 in the next cycle. Every clock enable is 0, `mem_self_ref`=1, and `mem_cke_hold` equals the inverse of `bkp_rst_n`.
- R11: In backup, `irq`, `mrst_n`, `sleep_req` and register writes have no effect. Only `por_n` low returns the block to run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, synchronous, active low |
| mrst_n | input | 1 | Manual reset, synchronous, active low |
| sleep_req | input | 1 | Sleep instruction strobe |
| deep_sel | input | 1 | Selects deep sleep for the next sleep strobe |
| sleep_self_ref | input | 1 | Memory refresh choice for light sleep (1 = self-refresh) |
| irq | input | 1 | Interrupt request, wake source |
| backup_req | input | 1 | Request to enter backup mode |
| bkp_rst_n | input | 1 | Backup reset input; low holds memory clock enable |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select for write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| cpu_clk_en | output | 1 | CPU clock enable |
| dma_grp_en | output | 2 | DMA group clock enables |
| dma_ch_en | output | 12 | Per-channel DMA clock enables |
| gfx_clk_en | output | 1 | Graphics transfer unit clock enable |
| periph_clk_en | output | 32 | Peripheral clock enables |
| mem_self_ref | output | 1 | Memory refresh mode: 1 self-refresh, 0 auto-refresh |
| mem_cke_hold | output | 1 | Holds memory clock enable high |
| mode_stat | output | 3 | 0 run, 1 sleep, 2 deep sleep, 3 backup, 4 waking |
| deep_err | output | 1 | Sticky refused-deep-sleep flag |

## Verification
The bench builds the block with its default parameters: 32-bit stop registers, twelve DMA channels in groups of six, and a deep-sleep mask covering peripheral bits 0 to 9. With these values, a single missing bit (bit 9) is enough to refuse deep sleep. Both channel-group boundaries show up on the 12-bit channel vector. Every level, each wake path and the backup lock can be reached with short directed sequences.

// File: rtl/pdm_pkg.sv
// Shared types for the power-down mode sequencer.
// Assumes: state codes 0..3 equal the externally visible mode codes.
package pdm_pkg;
    typedef enum logic [2:0] {
        ST_RUN    = 3'd0,
        ST_SLEEP  = 3'd1,
        ST_DEEP   = 3'd2,
        ST_BACKUP = 3'd3,
        ST_WAKE_A = 3'd4,
        ST_WAKE_B = 3'd5
    } pdm_state_e;

    localparam logic [2:0] MODE_WAKING = 3'd4;

    // Maps the internal state to the 3-bit status field.
    function automatic logic [2:0] mode_code(pdm_state_e s);
        return (s == ST_WAKE_A || s == ST_WAKE_B) ? MODE_WAKING : 3'(s);
    endfunction
endpackage

// File: rtl/pdm_stop_regs.sv
// Two module stop registers on a simple write/read bus.
// Assumes: writes are dropped while lock is high (backup); power-on reset clears both.
module pdm_stop_regs #(
    parameter int REG_W = 32
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             lock,
    input  logic             wr_en,
    input  logic             addr,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] stop_a,
    output logic [REG_W-1:0] stop_b,
    output logic [REG_W-1:0] rd_data
);
    // Register update: reset clear, otherwise accept unlocked writes.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            stop_a <= '0;
            stop_b <= '0;
        end else if (wr_en && !lock) begin
            if (addr) stop_b <= wr_data;
            else      stop_a <= wr_data;
        end
    end

    // Read mux.
    always_comb rd_data = addr ? stop_b : stop_a;

    // Backup lock keeps both registers unchanged.
    assert_backup_locks_regs_R11: assert property (@(posedge clk) disable iff (!por_n)
        lock |=> ($stable(stop_a) && $stable(stop_b)));
endmodule

// File: rtl/pdm_mode_fsm.sv
// Mode state machine: entry checks, wake sequencing, resets and backup.
// Assumes: synchronous resets; por_n outranks mrst_n, which outranks backup_req.
module pdm_mode_fsm
    import pdm_pkg::*;
#(
    parameter int               REG_W         = 32,
    parameter logic [REG_W-1:0] DEEP_REQ_MASK = 32'h0000_03FF
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             mrst_n,
    input  logic             sleep_req,
    input  logic             deep_sel,
    input  logic             irq,
    input  logic             backup_req,
    input  logic             sleep_self_ref,
    input  logic [REG_W-1:0] stop_a,
    output pdm_state_e       state,
    output logic             from_deep,
    output logic             self_lat,
    output logic             deep_err
);
    pdm_state_e nxt;
    logic       err_set;
    logic       deep_ok;

    // Deep sleep is allowed only with every required peripheral stopped.
    always_comb deep_ok = ((stop_a & DEEP_REQ_MASK) == DEEP_REQ_MASK);

    // Next-state selection with reset and backup priority.
    always_comb begin
        nxt     = state;
        err_set = 1'b0;
        if (state != ST_BACKUP) begin
            if (!mrst_n) begin
                nxt = ST_RUN;
            end else if (backup_req) begin
                nxt = ST_BACKUP;
            end else begin
                case (state)
                    ST_RUN: begin
                        if (sleep_req && !irq) begin
                            if (deep_sel && deep_ok) begin
                                nxt = ST_DEEP;
                            end else begin
                                nxt     = ST_SLEEP;
                                err_set = deep_sel;
                            end
                        end
                    end
                    ST_SLEEP, ST_DEEP: if (irq) nxt = ST_WAKE_A;
                    ST_WAKE_A:         nxt = ST_WAKE_B;
                    ST_WAKE_B:         nxt = ST_RUN;
                    default:           nxt = ST_RUN;
                endcase
            end
        end
    end

    // State, sticky error and entry-time latches.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            state     <= ST_RUN;
            deep_err  <= 1'b0;
            from_deep <= 1'b0;
            self_lat  <= 1'b0;
        end else begin
            state <= nxt;
            if (err_set) deep_err <= 1'b1;
            if (state == ST_RUN && nxt == ST_SLEEP) self_lat <= sleep_self_ref;
            if (nxt == ST_WAKE_A) from_deep <= (state == ST_DEEP);
        end
    end

    // Only power-on reset leaves backup.
    assert_backup_exit_por_only_R11: assert property (@(posedge clk) disable iff (!por_n)
        (state == ST_BACKUP) |=> (state == ST_BACKUP));

    // Interrupt together with the sleep strobe keeps run.
    assert_irq_cancels_entry_R7: assert property (@(posedge clk) disable iff (!por_n)
        (state == ST_RUN && sleep_req && irq && mrst_n && !backup_req) |=> (state == ST_RUN));

    // Refused deep sleep lands in light sleep with the error flag.
    assert_deep_refused_R6: assert property (@(posedge clk) disable iff (!por_n)
        (state == ST_RUN && sleep_req && deep_sel && !irq && mrst_n && !backup_req
         && ((stop_a & DEEP_REQ_MASK) != DEEP_REQ_MASK))
        |=> (state == ST_SLEEP && deep_err));

    // Error flag is sticky until power-on reset.
    assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!por_n)
        deep_err |=> deep_err);

    // Manual reset returns to run unless in backup.
    assert_mrst_to_run_R9: assert property (@(posedge clk) disable iff (!por_n)
        (!mrst_n && state != ST_BACKUP) |=> (state == ST_RUN));
endmodule

// File: rtl/pdm_clk_gate.sv
// Per-domain clock-enable and memory-refresh decode from the mode state.
// Assumes: stop bit 1 means stopped; domain stop bits are [NGRP-1:0] DMA groups, [NGRP] graphics.
module pdm_clk_gate
    import pdm_pkg::*;
#(
    parameter int REG_W  = 32,
    parameter int DMA_CH = 12,
    parameter int GRP_SZ = 6,
    localparam int NGRP  = DMA_CH / GRP_SZ
) (
    input  logic              clk,
    input  logic              por_n,
    input  pdm_state_e        state,
    input  logic              from_deep,
    input  logic              self_lat,
    input  logic [REG_W-1:0]  stop_a,
    input  logic [NGRP:0]     stop_dom,
    input  logic              bkp_rst_n,
    output logic              cpu_en,
    output logic [NGRP-1:0]   dma_grp_en,
    output logic [DMA_CH-1:0] dma_ch_en,
    output logic              gfx_en,
    output logic [REG_W-1:0]  periph_en,
    output logic              ref_self,
    output logic              cke_hold
);
    logic [NGRP-1:0] norm_dma;
    logic            norm_gfx;

    // Enables implied by the stop registers alone.
    always_comb begin
        norm_dma = ~stop_dom[NGRP-1:0];
        norm_gfx = ~stop_dom[NGRP];
    end

    // Per-state gating decode.
    always_comb begin
        cpu_en     = 1'b0;
        dma_grp_en = norm_dma;
        gfx_en     = norm_gfx;
        periph_en  = ~stop_a;
        ref_self   = 1'b0;
        cke_hold   = 1'b0;
        case (state)
            ST_RUN:   cpu_en = 1'b1;
            ST_SLEEP: ref_self = self_lat;
            ST_DEEP: begin
                dma_grp_en = '0;
                gfx_en     = 1'b0;
                ref_self   = 1'b1;
            end
            ST_BACKUP: begin
                dma_grp_en = '0;
                gfx_en     = 1'b0;
                periph_en  = '0;
                ref_self   = 1'b1;
                cke_hold   = !bkp_rst_n;
            end
            ST_WAKE_A: begin
                if (from_deep) begin
                    dma_grp_en = '0;
                    gfx_en     = 1'b0;
                end
            end
            ST_WAKE_B: cpu_en = 1'b0;
            default:   cpu_en = 1'b1;
        endcase
    end

    // Fan each group enable out to its channels.
    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        for (genvar c = 0; c < GRP_SZ; c++) begin : g_ch
            assign dma_ch_en[g*GRP_SZ + c] = dma_grp_en[g];
        end

        // Channels of a group never differ.
        assert_group_uniform_R3: assert property (@(posedge clk) disable iff (!por_n)
            ($countones(dma_ch_en[g*GRP_SZ +: GRP_SZ]) == 0) ||
            ($countones(dma_ch_en[g*GRP_SZ +: GRP_SZ]) == GRP_SZ));
    end
endmodule

// File: rtl/pdm_seq.sv
// Top of the power-down mode sequencer: stop registers, mode FSM, gating decode.
// Assumes: all inputs synchronous to clk; por_n is the only way out of backup.
module pdm_seq
    import pdm_pkg::*;
#(
    parameter int               REG_W         = 32,
    parameter int               DMA_CH        = 12,
    parameter int               GRP_SZ        = 6,
    parameter logic [REG_W-1:0] DEEP_REQ_MASK = 32'h0000_03FF,
    localparam int              NGRP          = DMA_CH / GRP_SZ
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              mrst_n,
    input  logic              sleep_req,
    input  logic              deep_sel,
    input  logic              sleep_self_ref,
    input  logic              irq,
    input  logic              backup_req,
    input  logic              bkp_rst_n,
    input  logic              reg_wr,
    input  logic              reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              cpu_clk_en,
    output logic [NGRP-1:0]   dma_grp_en,
    output logic [DMA_CH-1:0] dma_ch_en,
    output logic              gfx_clk_en,
    output logic [REG_W-1:0]  periph_clk_en,
    output logic              mem_self_ref,
    output logic              mem_cke_hold,
    output logic [2:0]        mode_stat,
    output logic              deep_err
);
    pdm_state_e       state;
    logic             from_deep;
    logic             self_lat;
    logic [REG_W-1:0] stop_a;
    logic [REG_W-1:0] stop_b;

    pdm_stop_regs #(.REG_W(REG_W)) u_regs (
        .clk     (clk),
        .por_n   (por_n),
        .lock    (state == ST_BACKUP),
        .wr_en   (reg_wr),
        .addr    (reg_addr),
        .wr_data (reg_wdata),
        .stop_a  (stop_a),
        .stop_b  (stop_b),
        .rd_data (reg_rdata)
    );

    pdm_mode_fsm #(.REG_W(REG_W), .DEEP_REQ_MASK(DEEP_REQ_MASK)) u_fsm (
        .clk            (clk),
        .por_n          (por_n),
        .mrst_n         (mrst_n),
        .sleep_req      (sleep_req),
        .deep_sel       (deep_sel),
        .irq            (irq),
        .backup_req     (backup_req),
        .sleep_self_ref (sleep_self_ref),
        .stop_a         (stop_a),
        .state          (state),
        .from_deep      (from_deep),
        .self_lat       (self_lat),
        .deep_err       (deep_err)
    );

    pdm_clk_gate #(.REG_W(REG_W), .DMA_CH(DMA_CH), .GRP_SZ(GRP_SZ)) u_gate (
        .clk        (clk),
        .por_n      (por_n),
        .state      (state),
        .from_deep  (from_deep),
        .self_lat   (self_lat),
        .stop_a     (stop_a),
        .stop_dom   (stop_b[NGRP:0]),
        .bkp_rst_n  (bkp_rst_n),
        .cpu_en     (cpu_clk_en),
        .dma_grp_en (dma_grp_en),
        .dma_ch_en  (dma_ch_en),
        .gfx_en     (gfx_clk_en),
        .periph_en  (periph_clk_en),
        .ref_self   (mem_self_ref),
        .cke_hold   (mem_cke_hold)
    );

    // Status field from the state.
    always_comb mode_stat = mode_code(state);

    // CPU clock returns only after refresh is back to auto and DMA is settled.
    assert_cpu_last_R8: assert property (@(posedge clk) disable iff (!por_n)
        ($rose(cpu_clk_en) && $past(mrst_n)) |-> ($past(!mem_self_ref) && ($past(dma_grp_en) == dma_grp_en)));

    // Deep sleep stops CPU, DMA and graphics and uses self-refresh.
    assert_deep_gating_R5: assert property (@(posedge clk) disable iff (!por_n)
        (mode_stat == 3'd2) |-> (!cpu_clk_en && dma_grp_en == '0 && !gfx_clk_en && mem_self_ref));

    // Backup holds memory clock enable while the backup reset is low.
    assert_backup_cke_R10: assert property (@(posedge clk) disable iff (!por_n)
        (mode_stat == 3'd3 && !bkp_rst_n) |-> (mem_cke_hold && !cpu_clk_en && periph_clk_en == '0));
endmodule

// File: tb/pdm_seq_tb.sv
module pdm_seq_tb;
    logic        clk = 1'b0;
    logic        por_n = 1'b0, mrst_n = 1'b1, sleep_req = 1'b0, deep_sel = 1'b0;
    logic        sleep_self_ref = 1'b0, irq = 1'b0, backup_req = 1'b0, bkp_rst_n = 1'b1;
    logic        reg_wr = 1'b0, reg_addr = 1'b0;
    logic [31:0] reg_wdata = '0, reg_rdata, periph_clk_en;
    logic        cpu_clk_en, gfx_clk_en, mem_self_ref, mem_cke_hold, deep_err;
    logic [1:0]  dma_grp_en;
    logic [11:0] dma_ch_en;
    logic [2:0]  mode_stat;
    int checks = 0, fails = 0;

    always #5 clk = ~clk;

    pdm_seq u_dut (.*);

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic a, logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic t_reset();
        por_n = 1'b0; tick(); tick(); por_n = 1'b1;
        reg_addr = 1'b0;
        chk("R1 mode", mode_stat, 0);
        chk("R1 cpu", cpu_clk_en, 1);
        chk("R1 dma", dma_ch_en, 12'hFFF);
        chk("R1 gfx", gfx_clk_en, 1);
        chk("R1 periph", periph_clk_en, 32'hFFFF_FFFF);
        chk("R1 refresh", mem_self_ref, 0);
        chk("R1 cke", mem_cke_hold, 0);
        chk("R1 err", deep_err, 0);
        chk("R1 rdata", reg_rdata, 0);
    endtask

    task automatic t_regs();
        wr(1'b0, 32'h0000_00F0);
        chk("R2 periph", periph_clk_en, 32'hFFFF_FF0F);
        chk("R2 read a", reg_rdata, 32'h0000_00F0);
        wr(1'b1, 32'h1);
        chk("R3 grp0 off", dma_ch_en, 12'hFC0);
        chk("R2 gfx on", gfx_clk_en, 1);
        wr(1'b1, 32'h6);
        chk("R3 grp1 off", dma_ch_en, 12'h03F);
        chk("R2 gfx off", gfx_clk_en, 0);
        chk("R2 read b", reg_rdata, 32'h6);
        wr(1'b1, 32'h0);
    endtask

    task automatic t_sleep();
        deep_sel = 1'b0; sleep_self_ref = 1'b1; sleep_req = 1'b1;
        tick(); sleep_req = 1'b0; sleep_self_ref = 1'b0;
        chk("R4 mode", mode_stat, 1);
        chk("R4 cpu", cpu_clk_en, 0);
        chk("R4 dma", dma_ch_en, 12'hFFF);
        chk("R4 refresh latched", mem_self_ref, 1);
        chk("R4 periph", periph_clk_en, 32'hFFFF_FF0F);
        irq = 1'b1; tick(); irq = 1'b0;
        chk("R8 waking", mode_stat, 4);
        chk("R8 refresh auto", mem_self_ref, 0);
        chk("R8 cpu still off", cpu_clk_en, 0);
        chk("R8 dma kept", dma_ch_en, 12'hFFF);
        tick();
        chk("R8 cpu off b", cpu_clk_en, 0);
        tick();
        chk("R8 cpu on", cpu_clk_en, 1);
        chk("R8 run", mode_stat, 0);
    endtask

    task automatic t_irq_cancel();
        sleep_req = 1'b1; irq = 1'b1; tick(); sleep_req = 1'b0; irq = 1'b0;
        chk("R7 run", mode_stat, 0);
        chk("R7 cpu", cpu_clk_en, 1);
        tick();
        chk("R7 run later", mode_stat, 0);
    endtask

    task automatic t_deep_refused();
        wr(1'b0, 32'h0000_01FF);
        deep_sel = 1'b1; sleep_req = 1'b1; tick(); sleep_req = 1'b0;
        chk("R6 sleep", mode_stat, 1);
        chk("R6 err", deep_err, 1);
        chk("R6 dma on", dma_ch_en, 12'hFFF);
        irq = 1'b1; tick(); irq = 1'b0; tick(); tick();
        chk("R6 back run", mode_stat, 0);
        chk("R6 err sticky", deep_err, 1);
    endtask

    task automatic t_deep();
        wr(1'b0, 32'h0000_03FF);
        deep_sel = 1'b1; sleep_req = 1'b1; tick(); sleep_req = 1'b0;
        chk("R5 mode", mode_stat, 2);
        chk("R5 cpu", cpu_clk_en, 0);
        chk("R5 dma", dma_ch_en, 0);
        chk("R5 gfx", gfx_clk_en, 0);
        chk("R5 refresh", mem_self_ref, 1);
        chk("R5 periph", periph_clk_en, 32'hFFFF_FC00);
        irq = 1'b1; tick(); irq = 1'b0;
        chk("R8 deep a refresh", mem_self_ref, 0);
        chk("R8 deep a dma", dma_ch_en, 0);
        chk("R8 deep a cpu", cpu_clk_en, 0);
        tick();
        chk("R8 deep b dma", dma_ch_en, 12'hFFF);
        chk("R8 deep b gfx", gfx_clk_en, 1);
        chk("R8 deep b cpu", cpu_clk_en, 0);
        tick();
        chk("R8 deep cpu on", cpu_clk_en, 1);
        chk("R8 deep run", mode_stat, 0);
    endtask

    task automatic t_mrst();
        sleep_req = 1'b1; tick(); sleep_req = 1'b0;
        chk("R9 in deep", mode_stat, 2);
        mrst_n = 1'b0; tick(); mrst_n = 1'b1;
        reg_addr = 1'b0; #1;
        chk("R9 run", mode_stat, 0);
        chk("R9 cpu", cpu_clk_en, 1);
        chk("R9 regs kept", reg_rdata, 32'h0000_03FF);
        chk("R9 err kept", deep_err, 1);
        deep_sel = 1'b0;
    endtask

    task automatic t_backup();
        backup_req = 1'b1; bkp_rst_n = 1'b0; tick(); backup_req = 1'b0;
        chk("R10 mode", mode_stat, 3);
        chk("R10 cpu", cpu_clk_en, 0);
        chk("R10 dma", dma_ch_en, 0);
        chk("R10 periph", periph_clk_en, 0);
        chk("R10 refresh", mem_self_ref, 1);
        chk("R10 cke held", mem_cke_hold, 1);
        bkp_rst_n = 1'b1; #1;
        chk("R10 cke released", mem_cke_hold, 0);
        irq = 1'b1; mrst_n = 1'b0; sleep_req = 1'b1;
        tick(); irq = 1'b0; mrst_n = 1'b1; sleep_req = 1'b0;
        wr(1'b0, 32'h0);
        reg_addr = 1'b0; #1;
        chk("R11 stays backup", mode_stat, 3);
        chk("R11 write ignored", reg_rdata, 32'h0000_03FF);
        por_n = 1'b0; tick(); por_n = 1'b1; #1;
        chk("R11 por exit", mode_stat, 0);
        chk("R1 regs cleared", reg_rdata, 0);
        chk("R1 err cleared", deep_err, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_regs();
        t_sleep();
        t_irq_cancel();
        t_deep_refused();
        t_deep();
        t_mrst();
        t_backup();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule